// File: doc/BRIEF.md
# Periodic Interval Timer with Programmable Interrupt Vector

This block is a single-CPU interval timer on a simple memory-mapped read/write port. Software first writes a reload period into the period register. The period is counted in bus clock cycles. Software then writes a control word that sets the run bit and also carries the interrupt vector number and the priority the timer will raise. From that point a down-counter counts off the period again and again. Each time the counter expires it emits a one-cycle request toward an interrupt controller, and that request carries the programmed vector and priority. The live count can be read back at any time.

To stop the timer, software writes zero to the control register. To reprogram it, software stops the timer, writes the new period and writes the control word again, so every new period starts from a fresh reload. A build-time parameter selects how the vector is formed. In direct mapping the vector field passes through unchanged. In folded mapping only vectors 64 to 127 can be produced, and the priority is merged into the low vector bits.

Top module: `interval_timer`

## Requirements
- R1: After reset the run bit is clear, every register reads zero, and `irq_valid` is low.
- R2: Writing the control register (offset 0x00) with bit 26 set while the timer is stopped loads the counter from the period register on that clock edge. A period of zero is loaded as 1. From the next cycle the count register (offset 0x14) reads the loaded value.
- R3: While the timer runs, the count drops by one per clock. On the edge where the count is 1, the counter reloads from the period register and `irq_valid` goes high for exactly the following cycle. The first request therefore comes P edges after the start write, and later requests follow every P edges, where P is the period (or 1 when the period is 0).
- R4: Writing zero to the control register stops the timer on that edge. The count then reads 0 and no request is raised until the next start.
- R5: With direct mapping (FOLD_MAP=0), `irq_vector` equals control bits 19:12 and `irq_prio` equals control bits 23:20.
- R6: With folded mapping (FOLD_MAP=1), `irq_vector` is binary 01 in bits 7:6, and bits 5:0 hold vector field bits 5:0 ORed with the priority shifted left by two. `irq_prio` still equals the priority field.
- R7: The control register keeps only bits 26 and 23:12, and all other bits read back as zero. Writes to the count register are ignored.
- R8: The period register (offset 0x10) reads back the value written. Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; the counter steps on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_valid | output | 1 | One-cycle interrupt request strobe |
| irq_vector | output | 8 | Vector number sent with the request |
| irq_prio | output | 4 | Priority sent with the request |

## Verification
The hardest case to reach is the exact phase of the request train. The first pulse must come exactly P edges after the start write, and every later pulse P edges after the one before. That must hold for periods of 0 and 1 as well as longer ones, and a stop must cut the train off in mid-count. The bench starts the timer from a known edge with random periods, vectors and priorities, and random junk in the unused control bits. It then compares the pulse and the count against a cycle-indexed expectation on every cycle, and runs two instances side by side, one per mapping mode.

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int ADDR_W   = 8,
  parameter int CNT_W    = 32,
  parameter bit FOLD_MAP = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_valid,
  output logic [7:0]        irq_vector,
  output logic [3:0]        irq_prio
);
  localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFS_PER  = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] OFS_CNT  = ADDR_W'(8'h14);
  localparam int RUN_BIT  = 26;
  localparam int PRIO_LSB = 20;
  localparam int VEC_LSB  = 12;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             run_q;
  logic [3:0]       prio_q;
  logic [7:0]       vec_q;
  logic [CNT_W-1:0] per_q;
  logic [CNT_W-1:0] cnt_q;
  logic             fire_q;

  wire wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
  wire wr_per  = bus_wr && (bus_addr == OFS_PER);
  wire start   = wr_ctrl && bus_wdata[RUN_BIT] && !run_q;
  wire stop    = wr_ctrl && !bus_wdata[RUN_BIT];
  wire [CNT_W-1:0] reload = (per_q == '0) ? ONE : per_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      prio_q <= '0;
      vec_q  <= '0;
      per_q  <= '0;
      cnt_q  <= '0;
      fire_q <= 1'b0;
    end else begin
      fire_q <= 1'b0;
      if (wr_ctrl) begin
        run_q  <= bus_wdata[RUN_BIT];
        prio_q <= bus_wdata[PRIO_LSB +: 4];
        vec_q  <= bus_wdata[VEC_LSB +: 8];
      end
      if (wr_per) per_q <= bus_wdata[CNT_W-1:0];
      if (stop)
        cnt_q <= '0;
      else if (start)
        cnt_q <= reload;
      else if (run_q) begin
        if (cnt_q == ONE) begin
          cnt_q  <= reload;
          fire_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - ONE;
        end
      end
    end
  end

  logic [31:0] per_ext, cnt_ext, ctrl_rd;
  always_comb begin
    per_ext = '0;
    cnt_ext = '0;
    per_ext[CNT_W-1:0] = per_q;
    cnt_ext[CNT_W-1:0] = cnt_q;
    ctrl_rd = '0;
    ctrl_rd[RUN_BIT] = run_q;
    ctrl_rd[PRIO_LSB +: 4] = prio_q;
    ctrl_rd[VEC_LSB +: 8]  = vec_q;
  end

  always_comb begin
    case (bus_addr)
      OFS_CTRL: bus_rdata = ctrl_rd;
      OFS_PER:  bus_rdata = per_ext;
      OFS_CNT:  bus_rdata = cnt_ext;
      default:  bus_rdata = '0;
    endcase
  end

  assign irq_valid = fire_q;
  assign irq_prio  = prio_q;

  generate
    if (FOLD_MAP) begin : g_fold
      assign irq_vector = {2'b01, vec_q[5:0] | {prio_q, 2'b00}};
    end else begin : g_direct
      assign irq_vector = vec_q;
    end
  endgenerate

  a_r2_start_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> cnt_q == $past(reload));
  a_r3_count_live: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> cnt_q != '0);
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && cnt_q != ONE) |=> !irq_valid);
  a_r4_stopped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (!irq_valid && cnt_q == '0));
  a_r6_fold_range: assert property (@(posedge clk) disable iff (!rst_n)
    (FOLD_MAP && irq_valid) |-> irq_vector[7:6] == 2'b01);
endmodule

// File: tb/interval_timer_tb.sv
module interval_timer_tb;
  localparam int CLK_PERIOD = 10;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rd_d, rd_f;
  logic val_d, val_f;
  logic [7:0] vec_d, vec_f;
  logic [3:0] pri_d, pri_f;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  interval_timer #(.ADDR_W(8), .CNT_W(32), .FOLD_MAP(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_d), .irq_valid(val_d),
    .irq_vector(vec_d), .irq_prio(pri_d));

  interval_timer #(.ADDR_W(8), .CNT_W(32), .FOLD_MAP(1'b1)) u_dut_fold (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_f), .irq_valid(val_f),
    .irq_vector(vec_f), .irq_prio(pri_f));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] fold_vec(input logic [7:0] v, input logic [3:0] p);
    return {2'b01, v[5:0] | {p, 2'b00}};
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic run_case(input logic [31:0] per, input logic [7:0] v,
                          input logic [3:0] p, input int cycles);
    logic [31:0] word;
    logic [31:0] eff;
    eff = (per == 0) ? 32'd1 : per;
    wr(8'h00, 32'h0);
    wr(8'h10, per);
    bus_addr = 8'h10;
    #1 check("R8 period readback", rd_d, per);
    word = ($urandom & 32'hFB00_0FFF) | (32'h1 << 26) | (32'(p) << 20) | (32'(v) << 12);
    wr(8'h00, word);
    bus_addr = 8'h00;
    #1 check("R7 ctrl readback masked", rd_d, word & 32'h04FF_F000);
    check("R5 direct vector", 32'(vec_d), 32'(v));
    check("R5 direct prio", 32'(pri_d), 32'(p));
    check("R6 folded vector", 32'(vec_f), 32'(fold_vec(v, p)));
    check("R6 folded prio", 32'(pri_f), 32'(p));
    bus_addr = 8'h14;
    #1 check("R2 count loaded", rd_d, eff);
    for (int k = 1; k <= cycles; k++) begin
      @(negedge clk);
      check("R3 pulse timing", 32'(val_d), 32'((k % eff) == 0));
      check("R3 pulse timing folded", 32'(val_f), 32'((k % eff) == 0));
      check("R3 count value", rd_d, eff - 32'(k % eff));
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    bus_addr = 8'h00;
    #1 check("R1 ctrl reset", rd_d, 0);
    bus_addr = 8'h10;
    #1 check("R1 period reset", rd_d, 0);
    bus_addr = 8'h14;
    #1 check("R1 count reset", rd_d, 0);
    check("R1 irq reset", 32'(val_d), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 irq after reset", 32'(val_d | val_f), 0);

    run_case(32'd0, 8'hC5, 4'hA, 6);
    run_case(32'd1, 8'h3F, 4'h0, 5);
    run_case(32'd2, 8'hFF, 4'hF, 8);
    for (int i = 0; i < 12; i++)
      run_case(32'($urandom_range(3, 25)), 8'($urandom), 4'($urandom), 60);

    wr(8'h14, 32'hDEAD_0000);
    bus_addr = 8'h14;
    #1 check("R7 count write ignored", (rd_d == 0) ? 32'd1 : 32'd0, 32'd0);
    bus_addr = 8'h3C;
    #1 check("R8 unmapped reads zero", rd_d, 0);

    wr(8'h00, 32'h0);
    bus_addr = 8'h14;
    #1 check("R4 count zero after stop", rd_d, 0);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      check("R4 no pulse when stopped", 32'(val_d | val_f), 0);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule